// File: doc/BRIEF.md
# Banked Command and Interrupt Controller

This block is the host-facing control core of a packet network controller. The host reaches it through an 8-bit register port with a 4-bit offset. Offset 0 is always the command register. The top two bits of that register choose which of four register banks the other fifteen offsets address. The block decodes the start, stop, transmit-request and remote-DMA fields of each command write. It keeps the controller online or offline and defers a stop until any frame in flight has ended.

Event pulses come from the transmit, receive and DMA logic outside this block. They are latched into an interrupt status register, which the host clears by writing ones. An enable register masks the latched bits, and the OR of the unmasked bits drives one interrupt line. The top status bit is a reset flag. It is owned by the controller and cannot be written by the host. A stop that takes effect sets it, and so does a receive-ring overwrite. A start command clears it, and so does the removal of a packet from the ring. Bank 0 holds configuration bytes that the host can only write there. Bank 2 reads them back. Bank 1 is a plain read/write bank.

Top module: `bank_cmd_irq_ctrl`

## Requirements
- R1: After reset the command register reads 0x01, the status register reads 0x80, `online`, `tx_req`, `irq`, `dma_abort` and `page_sel` are all 0, and `dma_op` is 0.
- R2: A read of offset 0 in any bank returns {page[1:0], dma_cmd[2:0], tx_req, online, stop_flag}, with bit 7 as the MSB. stop_flag is 1 while a stop is pending or while the block is offline. `page_sel` shows the page bits of the last command write.
- R3: The DMA field is command bits 5:3. When bit 5 is 1, `dma_abort` is 1 and `dma_op` is 0. Otherwise `dma_op` equals bits 4:3: 0 means none, 1 read, 2 write and 3 send.
- R4: A command write with bit 1 = 1 and bit 0 = 0 sets `online` and clears status bit 7 at the next clock edge. A command write with both bits 1:0 = 0 changes neither.
- R5: A command write with bit 0 = 1 requests a stop. `online` stays 1 while `tx_busy` or `rx_busy` is high. `online` falls, and status bit 7 is set, at the first edge where a stop is pending and both busy inputs are low.
- R6: A command write with bit 2 = 1 sets `tx_req`. Writing 0 to bit 2 leaves it unchanged. A `tx_done` pulse clears it. If a set and `tx_done` fall in the same cycle, the set wins.
- R7: A high bit i of `evt_pulse` (i = 0..6) sets status bit i. The bit then stays set until the host clears it.
- R8: In bank 0, writing offset 7 clears each status bit 0..6 whose data bit is 1. A data bit of 0 leaves the status bit unchanged. An event in the same cycle keeps its bit set.
- R9: `evt_pulse[4]` (overwrite) also sets status bit 7, and a `ring_drain` pulse clears it. Host writes to offset 7 have no effect on bit 7.
- R10: In bank 0, offset 15 is the enable register. Bits 6:0 are stored, and bit 7 always reads as 0. `irq` is 1 exactly when some status bit i in 0..6 and enable bit i are both 1.
- R11: In bank 0, writes to offsets 1-6 and 8-14 are stored. Bank-0 reads return the stored value only at offset 3; other offsets besides 0 and 7 read 0. Bank 2 reads return the stored value at offsets 1-6 and 8-14, the enable register at offset 15, and 0 at offset 7. Bank 2 writes to nonzero offsets are ignored.
- R12: Bank 1 offsets 1-15 are read/write registers, separate from bank 0. Bank 3 reads 0 at every nonzero offset and ignores writes there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Register offset within the selected bank |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| evt_pulse | input | 7 | Event pulses in status-bit order |
| ring_drain | input | 1 | Pulse: a packet was removed from the receive ring |
| tx_done | input | 1 | Pulse: transmission completed or aborted |
| tx_busy | input | 1 | A transmission is in progress |
| rx_busy | input | 1 | A reception is in progress |
| page_sel | output | 2 | Selected register bank |
| online | output | 1 | Controller started and not yet stopped |
| tx_req | output | 1 | Pending transmit request |
| dma_op | output | 2 | Decoded remote-DMA operation |
| dma_abort | output | 1 | Remote-DMA abort requested |
| irq | output | 1 | Interrupt output |

## Verification
Two pairs of functions can land in the same clock edge. The first pair is a host clear of a status bit and a new event on that bit. The second pair is the transmit-request set and its `tx_done` clear. Both are provoked by driving the write strobe and the pulse in the same cycle. Both are judged by reading the register afterwards: the event, or the new request, must survive. A seeded random phase mixes sparse event vectors with random clears and enable writes. After every cycle it compares the status register and `irq` against a bench model of set-over-clear.

// File: rtl/bank_ctl_pkg.sv
package bank_ctl_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_EVT  = 7;
  localparam int OFF_CMD  = 0;
  localparam int OFF_BND  = 3;
  localparam int OFF_STAT = 7;
  localparam int OFF_MASK = 15;

  typedef enum logic [1:0] {
    DMA_NONE  = 2'd0,
    DMA_READ  = 2'd1,
    DMA_WRITE = 2'd2,
    DMA_SEND  = 2'd3
  } dma_op_t;

  // Abort (top bit) overrides the operation field.
  function automatic dma_op_t dma_decode(input logic [2:0] cmd);
    if (cmd[2]) return DMA_NONE;
    return dma_op_t'(cmd[1:0]);
  endfunction

  function automatic logic irq_level(input logic [NUM_EVT-1:0] stat,
                                     input logic [NUM_EVT-1:0] mask);
    return |(stat & mask);
  endfunction

  // Set has priority over clear.
  function automatic logic [NUM_EVT-1:0] stat_next(input logic [NUM_EVT-1:0] cur,
                                                   input logic [NUM_EVT-1:0] set,
                                                   input logic [NUM_EVT-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [DATA_W-1:0] cmd_image(input logic [1:0] page,
                                                  input logic [2:0] dma,
                                                  input logic txr,
                                                  input logic run,
                                                  input logic stp);
    return {page, dma, txr, run, stp};
  endfunction
endpackage

// File: rtl/bank_cmd_unit.sv
module bank_cmd_unit
  import bank_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cr_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_done,
  input  logic              tx_busy,
  input  logic              rx_busy,
  output logic [1:0]        page,
  output logic [2:0]        dma_cmd,
  output logic              tx_req,
  output logic              running,
  output logic              stop_pend,
  output logic              start_evt,
  output logic              reset_entry
);
  logic stop_evt;

  assign start_evt   = cr_we & wdata[1] & ~wdata[0];
  assign stop_evt    = cr_we & wdata[0];
  assign reset_entry = stop_pend & ~tx_busy & ~rx_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page      <= 2'd0;
      dma_cmd   <= 3'd0;
      tx_req    <= 1'b0;
      running   <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      if (cr_we) begin
        page    <= wdata[7:6];
        dma_cmd <= wdata[5:3];
      end
      if (cr_we && wdata[2]) tx_req <= 1'b1;
      else if (tx_done)      tx_req <= 1'b0;
      if (stop_evt)          stop_pend <= 1'b1;
      else if (start_evt)    stop_pend <= 1'b0;
      else if (reset_entry)  stop_pend <= 1'b0;
      if (start_evt)         running <= 1'b1;
      else if (reset_entry)  running <= 1'b0;
    end
  end

  assert_start_online_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (running && !stop_pend));
  assert_stop_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (tx_busy || rx_busy) && !start_evt) |=> running);
  assert_txreq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !(cr_we && wdata[2])) |=> !tx_req);
endmodule

// File: rtl/bank_irq_unit.sv
module bank_irq_unit
  import bank_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stat_we,
  input  logic               mask_we,
  input  logic [NUM_EVT-1:0] wbits,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               reset_entry,
  input  logic               start_evt,
  input  logic               ring_drain,
  output logic [DATA_W-1:0]  stat,
  output logic [DATA_W-1:0]  mask,
  output logic               irq
);
  localparam int OVW_BIT = 4;

  logic [NUM_EVT-1:0] flags;
  logic [NUM_EVT-1:0] en;
  logic               rst_flag;
  logic [NUM_EVT-1:0] clr_vec;
  logic               rst_set;
  logic               rst_clr;

  assign clr_vec = stat_we ? wbits : '0;
  assign rst_set = reset_entry | evt[OVW_BIT];
  assign rst_clr = start_evt | ring_drain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags    <= '0;
      en       <= '0;
      rst_flag <= 1'b1;
    end else begin
      flags <= stat_next(flags, evt, clr_vec);
      if (mask_we) en <= wbits;
      if (rst_set)      rst_flag <= 1'b1;
      else if (rst_clr) rst_flag <= 1'b0;
    end
  end

  assign stat = {rst_flag, flags};
  assign mask = {1'b0, en};
  assign irq  = irq_level(flags, en);

  assert_event_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));
  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> ((flags & $past(wbits & ~evt)) == '0));
  assert_ovw_sets_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt[OVW_BIT] |=> rst_flag);
  assert_start_clears_rst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !rst_set) |=> !rst_flag);
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_ctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_we,
  input  logic              p1_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] p0_q,
  output logic [DATA_W-1:0] p1_q
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] bank0 [NREG];
  logic [DATA_W-1:0] bank1 [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank0[g] <= '0;
        bank1[g] <= '0;
      end else begin
        if (p0_we && addr == ADDR_W'(g)) bank0[g] <= wdata;
        if (p1_we && addr == ADDR_W'(g)) bank1[g] <= wdata;
      end
    end
  end

  assign p0_q = bank0[addr];
  assign p1_q = bank1[addr];
endmodule

// File: rtl/bank_cmd_irq_ctrl.sv
module bank_cmd_irq_ctrl
  import bank_ctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_we,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  input  logic [NUM_EVT-1:0]  evt_pulse,
  input  logic                ring_drain,
  input  logic                tx_done,
  input  logic                tx_busy,
  input  logic                rx_busy,
  output logic [1:0]          page_sel,
  output logic                online,
  output logic                tx_req,
  output logic [1:0]          dma_op,
  output logic                dma_abort,
  output logic                irq
);
  logic              at_cmd, at_stat, at_mask, at_bnd;
  logic              cr_we, stat_we, mask_we, p0_we, p1_we;
  logic [2:0]        dma_cmd;
  logic              stop_pend, start_evt, reset_entry;
  logic [DATA_W-1:0] stat, mask, p0_q, p1_q, cr_q;

  assign at_cmd  = host_addr == ADDR_W'(OFF_CMD);
  assign at_stat = host_addr == ADDR_W'(OFF_STAT);
  assign at_mask = host_addr == ADDR_W'(OFF_MASK);
  assign at_bnd  = host_addr == ADDR_W'(OFF_BND);

  assign cr_we   = host_we & at_cmd;
  assign stat_we = host_we & (page_sel == 2'd0) & at_stat;
  assign mask_we = host_we & (page_sel == 2'd0) & at_mask;
  assign p0_we   = host_we & (page_sel == 2'd0) & ~at_cmd & ~at_stat & ~at_mask;
  assign p1_we   = host_we & (page_sel == 2'd1) & ~at_cmd;

  bank_cmd_unit u_cmd (
    .clk(clk), .rst_n(rst_n), .cr_we(cr_we), .wdata(host_wdata),
    .tx_done(tx_done), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .page(page_sel), .dma_cmd(dma_cmd), .tx_req(tx_req), .running(online),
    .stop_pend(stop_pend), .start_evt(start_evt), .reset_entry(reset_entry)
  );

  bank_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .mask_we(mask_we),
    .wbits(host_wdata[NUM_EVT-1:0]), .evt(evt_pulse),
    .reset_entry(reset_entry), .start_evt(start_evt), .ring_drain(ring_drain),
    .stat(stat), .mask(mask), .irq(irq)
  );

  bank_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .p0_we(p0_we), .p1_we(p1_we),
    .addr(host_addr), .wdata(host_wdata), .p0_q(p0_q), .p1_q(p1_q)
  );

  assign dma_op    = dma_decode(dma_cmd);
  assign dma_abort = dma_cmd[2];
  assign cr_q      = cmd_image(page_sel, dma_cmd, tx_req, online, stop_pend | ~online);

  always_comb begin
    host_rdata = '0;
    if (at_cmd) begin
      host_rdata = cr_q;
    end else begin
      case (page_sel)
        2'd0: begin
          if (at_stat)     host_rdata = stat;
          else if (at_bnd) host_rdata = p0_q;
        end
        2'd1: host_rdata = p1_q;
        2'd2: begin
          if (at_mask)       host_rdata = mask;
          else if (!at_stat) host_rdata = p0_q;
        end
        default: host_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/bank_cmd_irq_ctrl_tb.sv
module bank_cmd_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [6:0] evt_pulse = '0;
  logic       ring_drain = 1'b0, tx_done = 1'b0, tx_busy = 1'b0, rx_busy = 1'b0;
  logic [1:0] page_sel, dma_op;
  logic       online, tx_req, dma_abort, irq;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  bank_cmd_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_pulse(evt_pulse),
    .ring_drain(ring_drain), .tx_done(tx_done), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .page_sel(page_sel), .online(online), .tx_req(tx_req), .dma_op(dma_op),
    .dma_abort(dma_abort), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  function automatic logic [7:0] exp_cr(input logic [1:0] pg, input logic [2:0] dm,
                                        input logic tr, input logic on, input logic sp);
    return {pg, dm, tr, on, sp | ~on};
  endfunction

  function automatic logic [1:0] exp_op(input logic [2:0] dm);
    return dm[2] ? 2'd0 : dm[1:0];
  endfunction

  logic [7:0] v;
  logic [7:0] shadow0 [16];
  logic [7:0] shadow1 [16];
  logic [6:0] m_stat, m_mask;
  logic       m_rst;

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 cmd", v, 8'h01);
    rd(7, v); chk("R1 stat", v, 8'h80);
    chk("R1 outs", {online, tx_req, irq, dma_abort, page_sel, dma_op}, 8'h00);

    // R4 start
    wr(0, 8'h02);
    chk("R4 online", {7'd0, online}, 8'h01);
    rd(7, v); chk("R4 rst cleared", v, 8'h00);
    wr(0, 8'h00);
    chk("R4 no-op keeps online", {7'd0, online}, 8'h01);

    // R3 DMA decode / R2 image
    for (int c = 0; c < 8; c++) begin
      wr(0, {2'b00, 3'(c), 3'b000});
      chk("R3 op", {6'd0, dma_op}, {6'd0, exp_op(3'(c))});
      chk("R3 abort", {7'd0, dma_abort}, {7'd0, c[2]});
    end
    wr(0, 8'h58);
    chk("R2 page_sel", {6'd0, page_sel}, 8'h01);
    rd(0, v); chk("R2 cmd image", v, exp_cr(2'd1, 3'b011, 1'b0, 1'b1, 1'b0));
    wr(0, 8'h00);

    // R6 transmit request
    wr(0, 8'h04);
    chk("R6 set", {7'd0, tx_req}, 8'h01);
    wr(0, 8'h00);
    chk("R6 zero keeps", {7'd0, tx_req}, 8'h01);
    rd(0, v); chk("R2 txreq bit", v, exp_cr(2'd0, 3'd0, 1'b1, 1'b1, 1'b0));
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    chk("R6 done clears", {7'd0, tx_req}, 8'h00);
    @(negedge clk);
    host_we = 1'b1; host_addr = 0; host_wdata = 8'h04; tx_done = 1'b1;
    @(negedge clk);
    host_we = 1'b0; tx_done = 1'b0;
    chk("R6 set wins", {7'd0, tx_req}, 8'h01);
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    chk("R6 cleared again", {7'd0, tx_req}, 8'h00);

    // R5 deferred stop
    tx_busy = 1'b1;
    wr(0, 8'h01);
    repeat (3) @(negedge clk);
    chk("R5 held tx", {7'd0, online}, 8'h01);
    rd(0, v); chk("R2 stop flag", v, 8'h03);
    rd(7, v); chk("R5 rst not yet", v, 8'h00);
    tx_busy = 1'b0; rx_busy = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 held rx", {7'd0, online}, 8'h01);
    rx_busy = 1'b0;
    @(negedge clk);
    chk("R5 offline", {7'd0, online}, 8'h00);
    rd(7, v); chk("R5 rst set", v, 8'h80);
    rd(0, v); chk("R2 stopped image", v, 8'h01);
    wr(0, 8'h02);
    rd(7, v); chk("R4 restart clears rst", v, 8'h00);

    // R9 reset flag by overwrite / drain
    @(negedge clk); evt_pulse = 7'h10; @(negedge clk); evt_pulse = '0;
    rd(7, v); chk("R9 ovw", v, 8'h90);
    wr(7, 8'h80);
    rd(7, v); chk("R9 host cannot clear", v, 8'h90);
    wr(7, 8'h10);
    rd(7, v); chk("R8 clear ovw bit", v, 8'h80);
    @(negedge clk); ring_drain = 1'b1; @(negedge clk); ring_drain = 1'b0;
    rd(7, v); chk("R9 drain", v, 8'h00);

    // R8 same-cycle event vs clear
    @(negedge clk); evt_pulse = 7'h01; @(negedge clk); evt_pulse = '0;
    @(negedge clk);
    host_we = 1'b1; host_addr = 7; host_wdata = 8'h01; evt_pulse = 7'h01;
    @(negedge clk);
    host_we = 1'b0; evt_pulse = '0;
    rd(7, v); chk("R8 event wins", v, 8'h01);
    wr(7, 8'h00);
    rd(7, v); chk("R8 zero keeps", v, 8'h01);
    wr(7, 8'h01);
    rd(7, v); chk("R8 cleared", v, 8'h00);

    // R10 mask
    wr(15, 8'hFF);
    chk("R10 idle irq", {7'd0, irq}, 8'h00);
    @(negedge clk); evt_pulse = 7'h04; @(negedge clk); evt_pulse = '0;
    chk("R10 irq", {7'd0, irq}, 8'h01);
    wr(15, 8'h7B);
    chk("R10 masked", {7'd0, irq}, 8'h00);
    wr(7, 8'h7F);
    wr(0, 8'h80);
    rd(15, v); chk("R10 mask readback", v, 8'h7B);
    wr(0, 8'h00);

    // R11 bank 0 config, bank 2 readback
    for (int o = 1; o < 15; o++) begin
      if (o != 7) begin
        shadow0[o] = 8'($urandom);
        wr(4'(o), shadow0[o]);
      end
    end
    rd(1, v); chk("R11 write-only", v, 8'h00);
    rd(3, v); chk("R11 bnd rw", v, shadow0[3]);
    wr(0, 8'h80);
    for (int o = 1; o < 15; o++) begin
      if (o != 7) begin
        rd(4'(o), v); chk("R11 bank2", v, shadow0[o]);
      end
    end
    rd(7, v); chk("R11 bank2 off7", v, 8'h00);
    wr(1, ~shadow0[1]);
    rd(1, v); chk("R11 bank2 write ignored", v, shadow0[1]);

    // R12 bank 1 and bank 3
    wr(0, 8'h40);
    for (int o = 1; o < 16; o++) begin
      shadow1[o] = 8'($urandom);
      wr(4'(o), shadow1[o]);
    end
    wr(0, 8'h00);
    wr(5, 8'h5A);
    wr(0, 8'hC0);
    rd(5, v); chk("R12 bank3 read", v, 8'h00);
    wr(5, 8'hA5);
    wr(0, 8'h40);
    for (int o = 1; o < 16; o++) begin
      rd(4'(o), v); chk("R12 bank1", v, shadow1[o]);
    end
    wr(0, 8'h00);

    // R7 R8 R10 random phase
    wr(7, 8'h7F);
    wr(15, 8'h00);
    m_stat = '0; m_mask = '0; m_rst = 1'b0;
    for (int it = 0; it < 300; it++) begin
      logic [6:0] ev;
      logic [7:0] d;
      int act;
      ev  = 7'($urandom) & 7'($urandom) & 7'($urandom);
      d   = 8'($urandom);
      act = $urandom % 4;
      @(negedge clk);
      evt_pulse = ev;
      if (act == 0) begin host_we = 1'b1; host_addr = 7; host_wdata = d; end
      else if (act == 1) begin host_we = 1'b1; host_addr = 15; host_wdata = d; end
      @(posedge clk);
      #1;
      host_we = 1'b0; evt_pulse = '0;
      if (act == 0) m_stat = m_stat & ~d[6:0];
      if (act == 1) m_mask = d[6:0];
      m_stat = m_stat | ev;
      if (ev[4]) m_rst = 1'b1;
      rd(7, v); chk("R7 R8 random stat", v, {m_rst, m_stat});
      chk("R10 random irq", {7'd0, irq}, {7'd0, |(m_stat & m_mask)});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule